// File: doc/BRIEF.md
# System Control Port Register File

This block is a byte-wide register file that sits on a 16-bit I/O port bus. A decoded write changes one of these outputs: a soft-reset level, a little-endian mode flag, a disk activity indicator, a 4-bit system control field, an I/O map mode bit, or one of two external lock-toggle strobes. The two strobes serve a non-volatile memory that lives elsewhere.

A decoded read returns one of the following:
- a fixed identification or feature byte;
- the stored value of a control register;
- one of two general-purpose scratch bytes.

Any port that nothing decodes reads back as 0xFF. An access to such a port also raises a one-cycle error pulse.

Read data is registered. It appears on the cycle after the read strobe and holds until the next read. Write effects also appear on the cycle after the write strobe. The bus master must not assert the read and write strobes in the same cycle.

Top module: `sysctl_portfile`

## Requirements
- R1: While `rst_n` is low at a clock edge, every stored bit, strobe, `rd_data` and `decode_err` goes to zero. This includes `soft_reset` being deasserted.
- R2: A write to port 0x0092 sets `soft_reset` to data bit 0 and `little_endian` to data bit 1 on the next cycle. A read of port 0x0092 returns 0x00.
- R3: These read-only ports return fixed bytes:

  | Port | Byte |
  |------|------|
  | 0x0800 | 0xEF |
  | 0x0802 | 0xAD |
  | 0x0803 | 0xE0 |
  | 0x080C | 0x3C |
  | 0x0810 | 0x39 |
  | 0x0818 | 0x00 |
  | 0x0823 | 0x03 |

- R4: Writes to ports 0x0800, 0x0802 and 0x0803 change no output and no read-back value.
- R5: Bit 0 of a write to port 0x0808 becomes `disk_led` on the next cycle.
- R6: A write to port 0x0810 pulses `lock_tog1`, and a write to port 0x0812 pulses `lock_tog2`. Each pulse is high for exactly the one cycle after the write, whatever the data. The two strobes are never high together.
- R7: A write to port 0x081C stores data bits 3:0 in `sys_ctl`. A read of 0x081C returns that value with bits 7:4 zero.
- R8: A write to port 0x0850 stores data bit 0 in `io_map_mode`. A read of 0x0850 returns it in bit 0, with the other bits zero.
- R9: A read of any port not listed in R2, R3, R7, R8 or R10 returns 0xFF. Port 0x0814 is an example. Writes to 0x0814 are accepted, have no effect and raise no error.
- R10: Ports 0x0398 and 0x0399 are two independent read/write scratch bytes.
- R11: `decode_err` is high for the one cycle after either of these accesses:
  - a read of a port with no read decode (any port other than 0x0092, the R3 ports, 0x0814, 0x081C, 0x0850, 0x0398 and 0x0399);
  - a write to a port with no write decode (any port other than 0x0092, 0x0800, 0x0802, 0x0803, 0x0808, 0x0810, 0x0812, 0x0814, 0x081C, 0x0850, 0x0398 and 0x0399).
- R12: `rd_data` changes only on the cycle after `rd_en`. It holds its value until the next read. A read in the same cycle as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | Port address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| soft_reset | output | 1 | Soft-reset request level |
| little_endian | output | 1 | Little-endian mode flag |
| disk_led | output | 1 | Disk activity indicator |
| lock_tog1 | output | 1 | Lock-toggle strobe 1 |
| lock_tog2 | output | 1 | Lock-toggle strobe 2 |
| sys_ctl | output | 4 | System control value |
| io_map_mode | output | 1 | I/O map mode bit |
| decode_err | output | 1 | One-cycle unmapped-access pulse |

## Verification
Every stored bit drives a port directly, so a corrupted register shows on its output pin on the cycle after the write that should have set it. A wrong decode shows in one of three ways on the cycle after the access: a wrong `rd_data` byte, a missing or extra strobe, or a spurious or absent `decode_err`. A scratch byte written to the wrong slot only appears at the next read of either slot. For that reason, the random phase interleaves writes and reads of both slots, so that such a fault is exposed within a few operations.

// File: rtl/sysctl_pkg.sv
// Shared port identifiers, port addresses and fixed read bytes for the
// system control register file. Assumes a 16-bit port address space.
package sysctl_pkg;

    localparam int ADDR_W = 16;

    typedef enum logic [3:0] {
        P_NONE, P_SPECIAL, P_CPUCFG, P_FEAT, P_STAT, P_DISK, P_EQUIP,
        P_LOCK1, P_LOCK2, P_L2INV, P_KEY, P_SYSCTL, P_CACHE, P_MAPSEL,
        P_SCRATCH
    } port_e;

    localparam logic [ADDR_W-1:0] A_SPECIAL = 16'h0092;
    localparam logic [ADDR_W-1:0] A_CPUCFG  = 16'h0800;
    localparam logic [ADDR_W-1:0] A_FEAT    = 16'h0802;
    localparam logic [ADDR_W-1:0] A_STAT    = 16'h0803;
    localparam logic [ADDR_W-1:0] A_DISK    = 16'h0808;
    localparam logic [ADDR_W-1:0] A_EQUIP   = 16'h080C;
    localparam logic [ADDR_W-1:0] A_LOCK1   = 16'h0810;
    localparam logic [ADDR_W-1:0] A_LOCK2   = 16'h0812;
    localparam logic [ADDR_W-1:0] A_L2INV   = 16'h0814;
    localparam logic [ADDR_W-1:0] A_KEY     = 16'h0818;
    localparam logic [ADDR_W-1:0] A_SYSCTL  = 16'h081C;
    localparam logic [ADDR_W-1:0] A_CACHE   = 16'h0823;
    localparam logic [ADDR_W-1:0] A_MAPSEL  = 16'h0850;
    localparam logic [ADDR_W-1:0] A_SCRBASE = 16'h0398;

    localparam logic [7:0] K_CPUCFG = 8'hEF;
    localparam logic [7:0] K_FEAT   = 8'hAD;
    localparam logic [7:0] K_STAT   = 8'hE0;
    localparam logic [7:0] K_EQUIP  = 8'h3C;
    localparam logic [7:0] K_XFEAT  = 8'h39;
    localparam logic [7:0] K_KEY    = 8'h00;
    localparam logic [7:0] K_CACHE  = 8'h03;
    localparam logic [7:0] K_UNMAP  = 8'hFF;

endpackage

// File: rtl/sysctl_decode.sv
// Address decoder: maps a port address to a port identifier, a scratch slot
// index, and flags telling whether that port accepts reads and writes.
// Assumes the scratch bytes occupy NSCR consecutive ports from A_SCRBASE.
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int NSCR  = 2,
    parameter int SCR_IW = (NSCR > 1) ? $clog2(NSCR) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output port_e             port_sel,
    output logic [SCR_IW-1:0] scr_idx,
    output logic              rd_ok,
    output logic              wr_ok
);

    logic [ADDR_W-1:0] scr_off;

    // Offset of the address into the scratch window.
    always_comb scr_off = addr - A_SCRBASE;

    // Exact-match decode of every named port.
    always_comb begin
        scr_idx = scr_off[SCR_IW-1:0];
        if (scr_off < ADDR_W'(NSCR)) port_sel = P_SCRATCH;
        else begin
            case (addr)
                A_SPECIAL: port_sel = P_SPECIAL;
                A_CPUCFG:  port_sel = P_CPUCFG;
                A_FEAT:    port_sel = P_FEAT;
                A_STAT:    port_sel = P_STAT;
                A_DISK:    port_sel = P_DISK;
                A_EQUIP:   port_sel = P_EQUIP;
                A_LOCK1:   port_sel = P_LOCK1;
                A_LOCK2:   port_sel = P_LOCK2;
                A_L2INV:   port_sel = P_L2INV;
                A_KEY:     port_sel = P_KEY;
                A_SYSCTL:  port_sel = P_SYSCTL;
                A_CACHE:   port_sel = P_CACHE;
                A_MAPSEL:  port_sel = P_MAPSEL;
                default:   port_sel = P_NONE;
            endcase
        end
    end

    // Which ports accept each access direction.
    always_comb begin
        rd_ok = !(port_sel inside {P_NONE, P_DISK, P_LOCK2});
        wr_ok = !(port_sel inside {P_NONE, P_EQUIP, P_KEY, P_CACHE});
    end

endmodule

// File: rtl/sysctl_regs.sv
// Register storage: control levels, masked system control field, map mode,
// scratch bytes and single-cycle lock strobes. Assumes wr_en is a one-cycle
// strobe qualified by the decoded port.
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int DW     = 8,
    parameter int SCTL_W = 4,
    parameter int NSCR   = 2,
    parameter int SCR_IW = (NSCR > 1) ? $clog2(NSCR) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  port_e                    port_sel,
    input  logic [SCR_IW-1:0]        scr_idx,
    input  logic [DW-1:0]            wr_data,
    output logic                     soft_reset,
    output logic                     little_endian,
    output logic                     disk_led,
    output logic                     lock_tog1,
    output logic                     lock_tog2,
    output logic [SCTL_W-1:0]        sys_ctl,
    output logic                     io_map_mode,
    output logic [NSCR-1:0][DW-1:0]  scratch
);

    // Control registers and strobes updated by decoded writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_reset    <= 1'b0;
            little_endian <= 1'b0;
            disk_led      <= 1'b0;
            lock_tog1     <= 1'b0;
            lock_tog2     <= 1'b0;
            sys_ctl       <= '0;
            io_map_mode   <= 1'b0;
        end else begin
            lock_tog1 <= wr_en && (port_sel == P_LOCK1);
            lock_tog2 <= wr_en && (port_sel == P_LOCK2);
            if (wr_en) begin
                case (port_sel)
                    P_SPECIAL: begin
                        soft_reset    <= wr_data[0];
                        little_endian <= wr_data[1];
                    end
                    P_DISK:   disk_led    <= wr_data[0];
                    P_SYSCTL: sys_ctl     <= wr_data[SCTL_W-1:0];
                    P_MAPSEL: io_map_mode <= wr_data[0];
                    default:  ;
                endcase
            end
        end
    end

    // One scratch byte per slot, written when its index is selected.
    for (genvar g = 0; g < NSCR; g++) begin : g_scr
        always_ff @(posedge clk) begin
            if (!rst_n) scratch[g] <= '0;
            else if (wr_en && port_sel == P_SCRATCH && scr_idx == SCR_IW'(g))
                scratch[g] <= wr_data;
        end
    end

    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lock_tog1, lock_tog2}));
    assert_strobe_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_tog1 || lock_tog2) |-> $past(wr_en));
    assert_reset_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && port_sel == P_SPECIAL) |=> (soft_reset == $past(wr_data[0])));
    assert_sysctl_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && port_sel == P_SYSCTL) |=> $stable(sys_ctl));

endmodule

// File: rtl/sysctl_rdmux.sv
// Read path: selects the byte for the decoded port, registers it on a read,
// and raises a one-cycle error pulse for accesses with no decode.
// Assumes rd_en and wr_en are not asserted together.
module sysctl_rdmux
    import sysctl_pkg::*;
#(
    parameter int DW     = 8,
    parameter int SCTL_W = 4,
    parameter int NSCR   = 2,
    parameter int SCR_IW = (NSCR > 1) ? $clog2(NSCR) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_en,
    input  logic                     wr_en,
    input  port_e                    port_sel,
    input  logic [SCR_IW-1:0]        scr_idx,
    input  logic                     rd_ok,
    input  logic                     wr_ok,
    input  logic [SCTL_W-1:0]        sys_ctl,
    input  logic                     io_map_mode,
    input  logic [NSCR-1:0][DW-1:0]  scratch,
    output logic [DW-1:0]            rd_data,
    output logic                     decode_err
);

    logic [DW-1:0] rd_mux;

    // Byte presented by the currently addressed port.
    always_comb begin
        case (port_sel)
            P_SPECIAL: rd_mux = '0;
            P_CPUCFG:  rd_mux = K_CPUCFG;
            P_FEAT:    rd_mux = K_FEAT;
            P_STAT:    rd_mux = K_STAT;
            P_EQUIP:   rd_mux = K_EQUIP;
            P_LOCK1:   rd_mux = K_XFEAT;
            P_KEY:     rd_mux = K_KEY;
            P_SYSCTL:  rd_mux = DW'(sys_ctl);
            P_CACHE:   rd_mux = K_CACHE;
            P_MAPSEL:  rd_mux = DW'(io_map_mode);
            P_SCRATCH: rd_mux = scratch[scr_idx];
            default:   rd_mux = K_UNMAP;
        endcase
    end

    // Capture read data on a read strobe and flag undecoded accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data    <= '0;
            decode_err <= 1'b0;
        end else begin
            if (rd_en) rd_data <= rd_mux;
            decode_err <= (rd_en && !rd_ok) || (wr_en && !wr_ok);
        end
    end

endmodule

// File: rtl/sysctl_portfile.sv
// Top of the system control port register file: decode, storage and read
// path. Assumes a byte-wide bus with one-cycle read or write strobes.
module sysctl_portfile
    import sysctl_pkg::*;
#(
    parameter int DW     = 8,
    parameter int SCTL_W = 4,
    parameter int NSCR   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     rd_data,
    output logic              soft_reset,
    output logic              little_endian,
    output logic              disk_led,
    output logic              lock_tog1,
    output logic              lock_tog2,
    output logic [SCTL_W-1:0] sys_ctl,
    output logic              io_map_mode,
    output logic              decode_err
);

    localparam int SCR_IW = (NSCR > 1) ? $clog2(NSCR) : 1;

    port_e                   port_sel;
    logic [SCR_IW-1:0]       scr_idx;
    logic                    rd_ok;
    logic                    wr_ok;
    logic [NSCR-1:0][DW-1:0] scratch;

    sysctl_decode #(.NSCR(NSCR), .SCR_IW(SCR_IW)) u_dec (
        .addr(addr), .port_sel(port_sel), .scr_idx(scr_idx),
        .rd_ok(rd_ok), .wr_ok(wr_ok)
    );

    sysctl_regs #(.DW(DW), .SCTL_W(SCTL_W), .NSCR(NSCR), .SCR_IW(SCR_IW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .port_sel(port_sel),
        .scr_idx(scr_idx), .wr_data(wr_data), .soft_reset(soft_reset),
        .little_endian(little_endian), .disk_led(disk_led),
        .lock_tog1(lock_tog1), .lock_tog2(lock_tog2), .sys_ctl(sys_ctl),
        .io_map_mode(io_map_mode), .scratch(scratch)
    );

    sysctl_rdmux #(.DW(DW), .SCTL_W(SCTL_W), .NSCR(NSCR), .SCR_IW(SCR_IW)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .port_sel(port_sel), .scr_idx(scr_idx), .rd_ok(rd_ok), .wr_ok(wr_ok),
        .sys_ctl(sys_ctl), .io_map_mode(io_map_mode), .scratch(scratch),
        .rd_data(rd_data), .decode_err(decode_err)
    );

    assert_unmapped_ff_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && port_sel inside {P_NONE, P_L2INV}) |=> (rd_data == {DW{1'b1}}));
    assert_err_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        decode_err |-> $past(rd_en || wr_en));
    assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: tb/tb_sysctl_portfile.sv
// Cycle-by-cycle reference model compared with every output on each clock.
module tb_sysctl_portfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        soft_reset, little_endian, disk_led, lock_tog1, lock_tog2;
    logic [3:0]  sys_ctl;
    logic        io_map_mode, decode_err;

    int total = 0, bad = 0;
    bit done = 0;
    string cur_tag = "R1";

    always #4 clk = ~clk;

    sysctl_portfile dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .soft_reset(soft_reset),
        .little_endian(little_endian), .disk_led(disk_led),
        .lock_tog1(lock_tog1), .lock_tog2(lock_tog2), .sys_ctl(sys_ctl),
        .io_map_mode(io_map_mode), .decode_err(decode_err)
    );

    // Reference state
    bit       started = 0, m_inrst = 1;
    int       m_sr, m_le, m_led, m_l1, m_l2, m_sc, m_map, m_err, m_rd;
    int       m_scr [2];
    string    m_rdtag = "R1";

    function automatic int ref_read(int a);
        case (a)
            'h092: return 0;
            'h800: return 'hEF;
            'h802: return 'hAD;
            'h803: return 'hE0;
            'h80C: return 'h3C;
            'h810: return 'h39;
            'h818: return 0;
            'h81C: return m_sc;
            'h823: return 3;
            'h850: return m_map;
            'h398: return m_scr[0];
            'h399: return m_scr[1];
            default: return 'hFF;
        endcase
    endfunction

    function automatic bit ref_rd_ok(int a);
        return a inside {'h092, 'h800, 'h802, 'h803, 'h80C, 'h810, 'h814,
                         'h818, 'h81C, 'h823, 'h850, 'h398, 'h399};
    endfunction

    function automatic bit ref_wr_ok(int a);
        return a inside {'h092, 'h800, 'h802, 'h803, 'h808, 'h810, 'h812,
                         'h814, 'h81C, 'h850, 'h398, 'h399};
    endfunction

    always @(posedge clk) begin
        started <= 1;
        m_inrst <= !rst_n;
        if (!rst_n) begin
            m_sr <= 0; m_le <= 0; m_led <= 0; m_l1 <= 0; m_l2 <= 0;
            m_sc <= 0; m_map <= 0; m_err <= 0; m_rd <= 0;
            m_scr[0] <= 0; m_scr[1] <= 0; m_rdtag <= "R1";
        end else begin
            m_l1  <= (wr_en && addr == 16'h810) ? 1 : 0;
            m_l2  <= (wr_en && addr == 16'h812) ? 1 : 0;
            m_err <= ((rd_en && !ref_rd_ok(int'(addr))) ||
                      (wr_en && !ref_wr_ok(int'(addr)))) ? 1 : 0;
            if (rd_en) begin
                m_rd <= ref_read(int'(addr));
                m_rdtag <= cur_tag;
            end else m_rdtag <= "R12";
            if (wr_en) begin
                case (int'(addr))
                    'h092: begin m_sr <= wr_data[0]; m_le <= wr_data[1]; end
                    'h808: m_led <= wr_data[0];
                    'h81C: m_sc <= wr_data & 8'h0F;
                    'h850: m_map <= wr_data[0];
                    'h398: m_scr[0] <= wr_data;
                    'h399: m_scr[1] <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare all outputs against the model away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            chk(m_inrst ? "R1" : "R2 soft_reset", soft_reset, m_sr);
            chk(m_inrst ? "R1" : "R2 little_endian", little_endian, m_le);
            chk(m_inrst ? "R1" : "R5 disk_led", disk_led, m_led);
            chk(m_inrst ? "R1" : "R6 lock_tog1", lock_tog1, m_l1);
            chk(m_inrst ? "R1" : "R6 lock_tog2", lock_tog2, m_l2);
            chk(m_inrst ? "R1" : "R7 sys_ctl", sys_ctl, m_sc);
            chk(m_inrst ? "R1" : "R8 io_map_mode", io_map_mode, m_map);
            chk(m_inrst ? "R1" : "R11 decode_err", decode_err, m_err);
            chk(m_inrst ? "R1" : m_rdtag, rd_data, m_rd);
        end
    end

    task automatic op(bit w, bit r, logic [15:0] a, logic [7:0] d, string tag);
        @(negedge clk);
        cur_tag = tag;
        wr_en = w; rd_en = r; addr = a; wr_data = d;
    endtask

    task automatic idle();
        op(0, 0, 16'h0, 8'h0, "R12");
    endtask

    logic [15:0] pool [18] = '{16'h092, 16'h800, 16'h802, 16'h803, 16'h808,
        16'h80C, 16'h810, 16'h812, 16'h814, 16'h818, 16'h81C, 16'h823,
        16'h850, 16'h398, 16'h399, 16'h000, 16'h801, 16'hFFFF};

    initial begin
        int unsigned s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2: reset level and endian flag
        op(1, 0, 16'h092, 8'h03, "R2"); op(0, 1, 16'h092, 8'h00, "R2");
        op(1, 0, 16'h092, 8'h02, "R2"); op(1, 0, 16'h092, 8'h00, "R2");
        // R3: constant bytes
        op(0, 1, 16'h800, 0, "R3"); op(0, 1, 16'h802, 0, "R3");
        op(0, 1, 16'h803, 0, "R3"); op(0, 1, 16'h80C, 0, "R3");
        op(0, 1, 16'h810, 0, "R3"); op(0, 1, 16'h818, 0, "R3");
        op(0, 1, 16'h823, 0, "R3");
        // R4: writes to identification ports ignored
        op(1, 0, 16'h800, 8'h00, "R4"); op(0, 1, 16'h800, 0, "R4");
        op(1, 0, 16'h802, 8'hFF, "R4"); op(0, 1, 16'h802, 0, "R4");
        op(1, 0, 16'h803, 8'h5A, "R4"); op(0, 1, 16'h803, 0, "R4");
        // R5: disk indicator
        op(1, 0, 16'h808, 8'hFF, "R5"); op(1, 0, 16'h808, 8'hFE, "R5");
        // R6: lock strobes, back-to-back and with zero data
        op(1, 0, 16'h810, 8'h00, "R6"); op(1, 0, 16'h810, 8'hFF, "R6");
        idle(); op(1, 0, 16'h812, 8'h00, "R6"); idle();
        // R7: masked control field and same-cycle read/write ordering
        op(1, 0, 16'h81C, 8'hFA, "R7"); op(0, 1, 16'h81C, 0, "R7");
        op(1, 1, 16'h81C, 8'h35, "R12"); op(0, 1, 16'h81C, 0, "R7");
        // R8: map mode
        op(1, 0, 16'h850, 8'hFF, "R8"); op(0, 1, 16'h850, 0, "R8");
        op(1, 0, 16'h850, 8'h02, "R8"); op(0, 1, 16'h850, 0, "R8");
        // R9: unmapped reads and ignored 0x814 write
        op(1, 0, 16'h814, 8'hA5, "R9"); op(0, 1, 16'h814, 0, "R9");
        op(0, 1, 16'h808, 0, "R9"); op(0, 1, 16'h1234, 0, "R9");
        // R10: scratch independence
        op(1, 0, 16'h398, 8'h11, "R10"); op(1, 0, 16'h399, 8'hEE, "R10");
        op(0, 1, 16'h398, 0, "R10"); op(0, 1, 16'h399, 0, "R10");
        // R11: write to a read-only constant port
        op(1, 0, 16'h80C, 8'h00, "R11"); op(1, 0, 16'h39A, 8'h00, "R11");
        // R12: hold after read
        idle(); idle(); idle();
        // Mixed random phase
        s = 32'h1234_5678;
        for (int i = 0; i < 600; i++) begin
            s = s * 1103515245 + 12345;
            case (s[31:30])
                2'd0, 2'd1: op(1, 0, pool[(s >> 8) % 18], s[23:16], "R10");
                2'd2: op(0, 1, pool[(s >> 8) % 18], 0, "R9");
                default: idle();
            endcase
        end
        idle(); idle();
        // R1: reset mid-run clears everything
        op(1, 0, 16'h092, 8'h01, "R1");
        @(negedge clk); rst_n = 1'b0; wr_en = 0; rd_en = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        idle(); idle();
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule